// File: doc/BRIEF.md
# Configurable MCU-Mapped I/O Port

This block is one general-purpose I/O port of configurable width. It sits in a microcontroller's register space behind a small byte-wide bus with a 3-bit register offset. Software sets the port up through five writable registers: output data, pin direction, pin role, alternate source and output drive style. A sixth register is read-only and returns the levels seen on the pins.

Each pin has its own multiplexer. An output pin can drive one of three things: its bit of the output data register, a signal from the on-chip programmable logic, or a bit of a bus address. The address bits come from a latch that captures them on the address-latch strobe. Any output pin can be switched to open-drain style. In that style it only ever pulls low and releases the line in place of driving a 1.

A build parameter limits how many low-order pins can become outputs. This supports a narrow variant of the port. The pad electronics are outside the block: it delivers a level and an output enable per pin.

Top module: `iop_port`

## Requirements
- R1: While reset is asserted, and after reset is released, every register reads as 0 and every pad_oe bit is 0 until software writes a register.
- R2: Register offsets are: 0 pin levels (read-only), 1 output data, 2 direction, 3 pin role, 4 drive style, 5 alternate source. A write with wr_en high takes effect at the rising clock edge, and reads of offsets 1 to 5 return the stored value (through the masking in R8).
- R3: A direction bit of 0 makes the pin an input, with pad_oe 0 and pad_out 0. A direction bit of 1 makes it an output.
- R4: Reading offset 0 returns the current pad_in levels combinationally. A write to offset 0 changes no register.
- R5: The address latch stores addr_in at every rising edge where ale is 1, and holds its value otherwise. An output pin whose pin role bit is 1 drives its latched address bit.
- R6: An output pin whose pin role bit is 0 and alternate source bit is 1 drives its logic_in bit. An output pin with both bits 0 drives its output data bit. The pin role bit takes priority over the alternate source bit.
- R7: With its drive style bit at 1, an output pin is open-drain. pad_out is 0, and pad_oe is 1 only when the selected value is 0. With the bit at 0, pad_oe is 1 and pad_out equals the selected value.
- R8: Only the DIR_IMPL lowest direction bits exist. Upper direction bits read as 0 and those pins never drive, whatever is written.
- R9: Offsets 6 and 7 read as 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register offset for reads and writes |
| wr_data | input | W | Write data |
| rd_data | output | W | Read data for the register at addr |
| ale | input | 1 | Address latch strobe |
| addr_in | input | W | Address bits to latch |
| logic_in | input | W | Outputs of the programmable logic, one per pin |
| pad_in | input | W | Pin levels |
| pad_out | output | W | Level driven per pin |
| pad_oe | output | W | Output enable per pin |

## Verification
The hardest situation to reach is a mix of modes across the port. In that case, neighbouring pins in the same cycle take their values from different sources, and some of those pins use open-drain style while others use push-pull. No single register write sets that up. The stimulus sweeps a sequence of arithmetic patterns for the four mode registers, the output data, the logic inputs and the latched address. Each step places every pin in a different combination, and the bench predicts every pin bit by bit. A second, narrow instance takes the same writes, so the masked upper pins are shown to stay inactive under every pattern.

// File: rtl/iop_pkg.sv
package iop_pkg;
  localparam int OFS_W = 3;
  typedef logic [OFS_W-1:0] ofs_t;

  localparam ofs_t OFS_PINS = 3'd0;
  localparam ofs_t OFS_DOUT = 3'd1;
  localparam ofs_t OFS_DIR  = 3'd2;
  localparam ofs_t OFS_ROLE = 3'd3;
  localparam ofs_t OFS_DRV  = 3'd4;
  localparam ofs_t OFS_ALT  = 3'd5;

  typedef enum logic [1:0] {
    SRC_OFF   = 2'd0,
    SRC_REG   = 2'd1,
    SRC_LOGIC = 2'd2,
    SRC_ADDR  = 2'd3
  } pin_src_e;
endpackage

// File: rtl/iop_regfile.sv
module iop_regfile
  import iop_pkg::*;
#(
  parameter int W        = 8,
  parameter int DIR_IMPL = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  ofs_t         ofs,
  input  logic [W-1:0] wr_data,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] rd_data,
  output logic [W-1:0] dout_q,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] role_q,
  output logic [W-1:0] drv_q,
  output logic [W-1:0] alt_q
);
  localparam int          DIR_N    = (DIR_IMPL > W) ? W : DIR_IMPL;
  localparam logic [W-1:0] DIR_MASK = {W{1'b1}} >> (W - DIR_N);

  logic         dout_en, dir_en, role_en, drv_en, alt_en;
  logic [W-1:0] dout_d, dir_d, role_d, drv_d, alt_d;

  always_comb begin
    dout_en = wr_en && (ofs == OFS_DOUT);
    dir_en  = wr_en && (ofs == OFS_DIR);
    role_en = wr_en && (ofs == OFS_ROLE);
    drv_en  = wr_en && (ofs == OFS_DRV);
    alt_en  = wr_en && (ofs == OFS_ALT);
    dout_d  = wr_data;
    dir_d   = wr_data & DIR_MASK;
    role_d  = wr_data;
    drv_d   = wr_data;
    alt_d   = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '0;
      dir_q  <= '0;
      role_q <= '0;
      drv_q  <= '0;
      alt_q  <= '0;
    end else begin
      if (dout_en) dout_q <= dout_d;
      if (dir_en)  dir_q  <= dir_d;
      if (role_en) role_q <= role_d;
      if (drv_en)  drv_q  <= drv_d;
      if (alt_en)  alt_q  <= alt_d;
    end
  end

  always_comb begin
    case (ofs)
      OFS_PINS: rd_data = pad_in;
      OFS_DOUT: rd_data = dout_q;
      OFS_DIR:  rd_data = dir_q;
      OFS_ROLE: rd_data = role_q;
      OFS_DRV:  rd_data = drv_q;
      OFS_ALT:  rd_data = alt_q;
      default:  rd_data = '0;
    endcase
  end
endmodule

// File: rtl/iop_addr_latch.sv
module iop_addr_latch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ale,
  input  logic [W-1:0] addr_in,
  output logic [W-1:0] addr_q
);
  logic [W-1:0] addr_d;

  always_comb addr_d = addr_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   addr_q <= '0;
    else if (ale) addr_q <= addr_d;
  end
endmodule

// File: rtl/iop_pin_mux.sv
module iop_pin_mux
  import iop_pkg::*;
(
  input  logic dir,
  input  logic role,
  input  logic alt,
  input  logic drv,
  input  logic dout,
  input  logic logic_bit,
  input  logic addr_bit,
  output logic pad_out,
  output logic pad_oe
);
  pin_src_e src;
  logic     val;

  always_comb begin
    if (!dir)      src = SRC_OFF;
    else if (role) src = SRC_ADDR;
    else if (alt)  src = SRC_LOGIC;
    else           src = SRC_REG;
  end

  always_comb begin
    case (src)
      SRC_REG:   val = dout;
      SRC_LOGIC: val = logic_bit;
      SRC_ADDR:  val = addr_bit;
      default:   val = 1'b0;
    endcase
  end

  always_comb begin
    if (src == SRC_OFF) begin
      pad_oe  = 1'b0;
      pad_out = 1'b0;
    end else if (drv) begin
      pad_oe  = ~val;
      pad_out = 1'b0;
    end else begin
      pad_oe  = 1'b1;
      pad_out = val;
    end
  end
endmodule

// File: rtl/iop_port.sv
module iop_port
  import iop_pkg::*;
#(
  parameter int W        = 8,
  parameter int DIR_IMPL = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [2:0]   addr,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] rd_data,
  input  logic         ale,
  input  logic [W-1:0] addr_in,
  input  logic [W-1:0] logic_in,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe
);
  logic rst_meta, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  logic [W-1:0] dout_q, dir_q, role_q, drv_q, alt_q, addr_q;

  iop_regfile #(.W(W), .DIR_IMPL(DIR_IMPL)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .ofs(addr),
    .wr_data(wr_data), .pad_in(pad_in), .rd_data(rd_data),
    .dout_q(dout_q), .dir_q(dir_q), .role_q(role_q),
    .drv_q(drv_q), .alt_q(alt_q)
  );

  iop_addr_latch #(.W(W)) u_alat (
    .clk(clk), .rst_n(rst_sync_n), .ale(ale),
    .addr_in(addr_in), .addr_q(addr_q)
  );

  for (genvar i = 0; i < W; i++) begin : g_pin
    iop_pin_mux u_mux (
      .dir(dir_q[i]), .role(role_q[i]), .alt(alt_q[i]), .drv(drv_q[i]),
      .dout(dout_q[i]), .logic_bit(logic_in[i]), .addr_bit(addr_q[i]),
      .pad_out(pad_out[i]), .pad_oe(pad_oe[i])
    );
  end
endmodule

// File: rtl/iop_port_chk.sv
module iop_port_chk
  import iop_pkg::*;
#(
  parameter int W        = 8,
  parameter int DIR_IMPL = 8
) (
  input logic         clk,
  input logic         rst_sync_n,
  input logic         wr_en,
  input logic [2:0]   addr,
  input logic [W-1:0] wr_data,
  input logic [W-1:0] rd_data,
  input logic         ale,
  input logic [W-1:0] addr_in,
  input logic [W-1:0] addr_q,
  input logic [W-1:0] drv_q,
  input logic [W-1:0] pad_in,
  input logic [W-1:0] pad_out,
  input logic [W-1:0] pad_oe
);
  localparam int           DIR_N    = (DIR_IMPL > W) ? W : DIR_IMPL;
  localparam logic [W-1:0] DIR_MASK = {W{1'b1}} >> (W - DIR_N);

  // R2: data written to output register reads back next cycle
  a_r2_write_readback: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && addr == OFS_DOUT) |=> (addr != OFS_DOUT || rd_data == $past(wr_data)));

  // R3: cleared direction bits stop driving
  a_r3_input_no_drive: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && addr == OFS_DIR) |=> ((pad_oe & ~$past(wr_data)) == '0));

  // R4: pin-level register follows pad_in
  a_r4_pins_live: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (addr == OFS_PINS) |-> (rd_data == pad_in));

  // R5: latch captures on strobe
  a_r5_latch_capture: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ale |=> (addr_q == $past(addr_in)));

  // R5: latch holds without strobe
  a_r5_latch_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !ale |=> $stable(addr_q));

  // R7: open-drain pins never drive a high level
  a_r7_od_low_only: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((pad_out & drv_q) == '0));

  // R8: unimplemented direction bits never enable a driver
  a_r8_upper_quiet: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((pad_oe & ~DIR_MASK) == '0));

  // R9: unused offsets read 0
  a_r9_unused_zero: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (addr >= 3'd6) |-> (rd_data == '0));
endmodule

bind iop_port iop_port_chk #(.W(W), .DIR_IMPL(DIR_IMPL)) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .wr_en(wr_en), .addr(addr),
  .wr_data(wr_data), .rd_data(rd_data), .ale(ale), .addr_in(addr_in),
  .addr_q(addr_q), .drv_q(drv_q), .pad_in(pad_in), .pad_out(pad_out),
  .pad_oe(pad_oe)
);

// File: tb/iop_port_bench.sv
`timescale 1ns/1ps
module iop_port_bench;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         wr_en;
  logic [2:0]   addr;
  logic [W-1:0] wr_data, addr_in, logic_in, pad_in;
  logic         ale;
  logic [W-1:0] rd_data, pad_out, pad_oe;
  logic [W-1:0] n_rd_data, n_pad_out, n_pad_oe;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #5 clk = ~clk;

  iop_port #(.W(W), .DIR_IMPL(8)) u_iop_port (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .ale(ale), .addr_in(addr_in), .logic_in(logic_in),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  iop_port #(.W(W), .DIR_IMPL(4)) u_narrow (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(n_rd_data), .ale(ale), .addr_in(addr_in), .logic_in(logic_in),
    .pad_in(pad_in), .pad_out(n_pad_out), .pad_oe(n_pad_oe)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] o, input logic [W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = o; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] o);
    addr = o;
    #1;
  endtask

  task automatic latch(input logic [W-1:0] a);
    @(negedge clk);
    ale = 1'b1; addr_in = a;
    @(negedge clk);
    ale = 1'b0; addr_in = ~a;
  endtask

  // Model from R3, R5, R6, R7
  task automatic expect_pins(input logic [W-1:0] dir, role, alt, drv, dout, lg, ad,
                             output logic [W-1:0] eo, eoe);
    for (int i = 0; i < W; i++) begin
      logic v;
      v = role[i] ? ad[i] : (alt[i] ? lg[i] : dout[i]);
      if (!dir[i])     begin eoe[i] = 1'b0; eo[i] = 1'b0; end
      else if (drv[i]) begin eoe[i] = ~v;   eo[i] = 1'b0; end
      else             begin eoe[i] = 1'b1; eo[i] = v;    end
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] eo, eoe;
    rst_n = 1'b0; wr_en = 1'b0; addr = 3'd0; wr_data = '0; ale = 1'b0;
    addr_in = '0; logic_in = '0; pad_in = 8'h3C;
    repeat (3) @(negedge clk);
    // R1 while in reset
    chk("R1 oe in reset", pad_oe, 8'h00);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int o = 1; o <= 5; o++) begin
      rd(3'(o));
      chk("R1 register clear", rd_data, 8'h00);
    end
    chk("R1 oe after reset", pad_oe, 8'h00);
    chk("R1 out after reset", pad_out, 8'h00);

    // R2 readback of every writable register
    for (int o = 1; o <= 5; o++) begin
      wr(3'(o), 8'h5A ^ 8'(o));
      rd(3'(o));
      chk("R2 readback", rd_data, 8'h5A ^ 8'(o));
    end
    for (int o = 1; o <= 5; o++) wr(3'(o), 8'h00);

    // R4 live pin levels, writes to offset 0 ignored
    for (int v = 0; v < 256; v += 37) begin
      pad_in = 8'(v);
      rd(3'd0);
      chk("R4 pins live", rd_data, 8'(v));
    end
    wr(3'd0, 8'hFF);
    for (int o = 1; o <= 5; o++) begin
      rd(3'(o));
      chk("R4 write to pins ignored", rd_data, 8'h00);
    end

    // R9 unused offsets
    wr(3'd6, 8'hFF);
    wr(3'd7, 8'hFF);
    rd(3'd6); chk("R9 offset 6 zero", rd_data, 8'h00);
    rd(3'd7); chk("R9 offset 7 zero", rd_data, 8'h00);
    for (int o = 1; o <= 5; o++) begin
      rd(3'(o));
      chk("R9 write to unused ignored", rd_data, 8'h00);
    end
    chk("R9 no drive", pad_oe, 8'h00);

    // R3 push-pull register output
    wr(3'd1, 8'hC5);
    wr(3'd2, 8'hF0);
    #1;
    chk("R3 oe follows dir", pad_oe, 8'hF0);
    chk("R3 out from data reg", pad_out, 8'hC0);

    // R8 narrow variant
    wr(3'd2, 8'hFF);
    rd(3'd2);
    chk("R8 wide dir readback", rd_data, 8'hFF);
    chk("R8 narrow dir readback", n_rd_data, 8'h0F);
    chk("R8 narrow oe", n_pad_oe, 8'h0F);
    chk("R8 narrow out", n_pad_out, 8'h05);

    // R5 latch hold without strobe
    latch(8'hA6);
    wr(3'd3, 8'hFF);
    addr_in = 8'h00;
    repeat (2) @(negedge clk);
    chk("R5 address out", pad_out, 8'hA6);
    chk("R8 narrow address out", n_pad_out, 8'h06);

    // R5 R6 R7 mixed-mode sweep
    for (int k = 0; k < 48; k++) begin
      logic [W-1:0] dir, role, alt, drv, dout, lg, ad;
      dir  = 8'(k * 29 + 3);
      role = 8'(k * 53 + 7);
      alt  = 8'(k * 71 + 1);
      drv  = 8'(k * 13 + 5);
      dout = 8'(k * 97);
      lg   = 8'(~(k * 41));
      ad   = 8'(k * 11 + 90);
      wr(3'd2, dir); wr(3'd3, role); wr(3'd5, alt); wr(3'd4, drv); wr(3'd1, dout);
      logic_in = lg;
      latch(ad);
      #1;
      expect_pins(dir, role, alt, drv, dout, lg, ad, eo, eoe);
      chk("R6 R7 mixed out", pad_out, eo);
      chk("R5 R7 mixed oe", pad_oe, eoe);
      expect_pins(dir & 8'h0F, role, alt, drv, dout, lg, ad, eo, eoe);
      chk("R8 narrow mixed out", n_pad_out, eo);
      chk("R8 narrow mixed oe", n_pad_oe, eoe);
    end

    // R1 reset clears again
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 oe on reset", pad_oe, 8'h00);
    rd(3'd2);
    chk("R1 dir on reset", rd_data, 8'h00);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule